// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a time-of-day value as a seconds count and a sub-second count, both clocked by a reference clock. Each cycle in which the tick input is high, a programmable increment is added to the sub-second count. When the sum goes beyond the rollover limit, the sub-second count wraps and the seconds count advances by one.

A mode input selects the rollover limit. In decimal mode the sub-second count holds true nanoseconds and wraps after 999,999,999. In binary mode it is a binary fraction of a second and wraps after 0x7FFFFFFF. Software writes the increment into an internal register. The value must suit both the reference clock frequency and the chosen mode. A load strobe sets both fields at once so that software can establish the time.

Top module: `ptp_time_counter`

## Requirements
- R1: A synchronous active-high reset clears the seconds output, the sub-second output and the increment register to zero.
- R2: While the increment register holds zero, ticks leave both outputs unchanged.
- R3: On a tick without load, if the sub-second value plus the increment does not exceed the active limit, the new sub-second value is that sum and the seconds value is unchanged.
- R4: With mode input 1 (decimal), the limit is 999,999,999. A tick whose sum S exceeds it gives sub-second S − 1,000,000,000 and advances seconds by one.
- R5: With mode input 0 (binary), the limit is 0x7FFFFFFF. A tick whose sum S exceeds it gives sub-second S − 0x80000000 and advances seconds by one.
- R6: In a cycle with neither tick nor load, both outputs hold their values.
- R7: A load strobe sets seconds and sub-second to the load inputs on the next edge. It takes priority over a tick in the same cycle.
- R8: A write of the increment register applies only to ticks in later cycles. A tick in the same cycle as the write uses the previous increment.
- R9: A carry out of the sub-second count when seconds is 0xFFFFFFFF wraps the seconds count to zero.
- R10: The mode input is sampled on every tick, so a change of mode applies to the very next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advance the time by the increment this cycle |
| roll_dec | input | 1 | Rollover select: 1 = decimal (999,999,999), 0 = binary (0x7FFFFFFF) |
| inc_we | input | 1 | Write strobe for the increment register |
| inc_val | input | 31 | New increment value |
| ld_en | input | 1 | Load strobe for the time |
| ld_sec | input | 32 | Seconds value to load |
| ld_nsec | input | 31 | Sub-second value to load |
| sec_q | output | 32 | Current seconds count (registered) |
| nsec_q | output | 31 | Current sub-second count (registered) |

## Verification
Every result is due exactly one clock edge after the cycle that requests it. A tick, a load or a reset sampled at an edge is visible on sec_q and nsec_q right after that edge. An increment write sampled at an edge affects only ticks sampled at later edges. The bench drives inputs on the falling edge, waits for the rising edge, and compares the outputs 1 ns later against a reference model. The model applies each cycle's request using the increment held before that cycle's write, which matches this one-edge latency.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int unsigned DEC_LIMIT = 32'd999_999_999;

  typedef enum logic {
    ROLL_BIN = 1'b0,
    ROLL_DEC = 1'b1
  } roll_mode_e;
endpackage

// File: rtl/ptp_tc_inc_reg.sv
module ptp_tc_inc_reg #(
  parameter int NSEC_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [NSEC_W-1:0] din,
  output logic [NSEC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/ptp_tc_subsec.sv
module ptp_tc_subsec
  import ptp_tc_pkg::*;
#(
  parameter int NSEC_W = 31
) (
  input  logic              mode,
  input  logic [NSEC_W-1:0] cur,
  input  logic [NSEC_W-1:0] inc,
  output logic [NSEC_W-1:0] nxt,
  output logic              carry
);
  localparam int SUM_W = NSEC_W + 1;
  localparam logic [SUM_W-1:0] BIN_LIM = {1'b0, {NSEC_W{1'b1}}};
  localparam logic [SUM_W-1:0] DEC_LIM = SUM_W'(DEC_LIMIT);

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] lim;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    sum     = {1'b0, cur} + {1'b0, inc};
    lim     = (roll_mode_e'(mode) == ROLL_DEC) ? DEC_LIM : BIN_LIM;
    carry   = (sum > lim);
    wrapped = sum - lim - 1'b1;
    nxt     = carry ? wrapped[NSEC_W-1:0] : sum[NSEC_W-1:0];
  end
endmodule

// File: rtl/ptp_tc_sec_cnt.sv
module ptp_tc_sec_cnt #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  input  logic             step,
  output logic [SEC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= q + 1'b1;
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int NSEC_W = 31,
  parameter int SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              roll_dec,
  input  logic              inc_we,
  input  logic [NSEC_W-1:0] inc_val,
  input  logic              ld_en,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [NSEC_W-1:0] ld_nsec,
  output logic [SEC_W-1:0]  sec_q,
  output logic [NSEC_W-1:0] nsec_q
);
  logic [NSEC_W-1:0] inc_q;
  logic [NSEC_W-1:0] nsec_nxt;
  logic              wrap;

  ptp_tc_inc_reg #(.NSEC_W(NSEC_W)) inc_i (
    .clk (clk),
    .rst (rst),
    .we  (inc_we),
    .din (inc_val),
    .q   (inc_q)
  );

  ptp_tc_subsec #(.NSEC_W(NSEC_W)) sub_i (
    .mode  (roll_dec),
    .cur   (nsec_q),
    .inc   (inc_q),
    .nxt   (nsec_nxt),
    .carry (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)        nsec_q <= '0;
    else if (ld_en) nsec_q <= ld_nsec;
    else if (tick)  nsec_q <= nsec_nxt;
  end

  ptp_tc_sec_cnt #(.SEC_W(SEC_W)) sec_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_en),
    .load_val (ld_sec),
    .step     (tick & wrap),
    .q        (sec_q)
  );
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk #(
  parameter int NSEC_W = 31,
  parameter int SEC_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              roll_dec,
  input logic              ld_en,
  input logic [SEC_W-1:0]  ld_sec,
  input logic [NSEC_W-1:0] ld_nsec,
  input logic [NSEC_W-1:0] inc_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic [NSEC_W-1:0] nsec_q
);
  localparam logic [NSEC_W-1:0] DEC_LIM = NSEC_W'(ptp_tc_pkg::DEC_LIMIT);

  assert_reset_zero_R1: assert property (@(posedge clk)
    $past(rst) |-> (sec_q == '0 && nsec_q == '0));

  assert_zero_inc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && inc_q == '0) |=> ($stable(sec_q) && $stable(nsec_q)));

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));

  assert_dec_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && roll_dec && nsec_q <= DEC_LIM && inc_q <= DEC_LIM)
      |=> (nsec_q <= DEC_LIM));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_en) |=> ($stable(sec_q) && $stable(nsec_q)));

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (sec_q == $past(ld_sec) && nsec_q == $past(ld_nsec)));
endmodule

bind ptp_time_counter ptp_time_counter_chk #(.NSEC_W(NSEC_W), .SEC_W(SEC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .roll_dec (roll_dec),
  .ld_en    (ld_en),
  .ld_sec   (ld_sec),
  .ld_nsec  (ld_nsec),
  .inc_q    (inc_q),
  .sec_q    (sec_q),
  .nsec_q   (nsec_q)
);

// File: tb/ptp_time_counter_tb_top.sv
`timescale 1ns/1ps
module ptp_time_counter_tb_top;
  localparam int NW = 31;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0, roll_dec = 1'b0, inc_we = 1'b0, ld_en = 1'b0;
  logic [NW-1:0] inc_val = '0, ld_nsec = '0;
  logic [SW-1:0] ld_sec = '0;
  logic [SW-1:0] sec_q;
  logic [NW-1:0] nsec_q;

  int checks = 0, failures = 0;
  logic [SW-1:0] e_sec = '0;
  logic [NW-1:0] e_nsec = '0, e_inc = '0;

  always #2.5 clk = ~clk;

  ptp_time_counter dut_i (
    .clk(clk), .rst(rst), .tick(tick), .roll_dec(roll_dec),
    .inc_we(inc_we), .inc_val(inc_val), .ld_en(ld_en),
    .ld_sec(ld_sec), .ld_nsec(ld_nsec), .sec_q(sec_q), .nsec_q(nsec_q)
  );

  function automatic logic [32:0] limit_of(input logic m);
    return m ? 33'd999_999_999 : 33'h7FFF_FFFF;
  endfunction

  task automatic model_step();
    logic [32:0] s;
    if (rst) begin
      e_sec = '0; e_nsec = '0; e_inc = '0;
      return;
    end
    if (ld_en) begin
      e_sec = ld_sec; e_nsec = ld_nsec;
    end else if (tick) begin
      s = {2'b0, e_nsec} + {2'b0, e_inc};
      if (s > limit_of(roll_dec)) begin
        s = s - limit_of(roll_dec) - 1;
        e_sec = e_sec + 1;
      end
      e_nsec = s[NW-1:0];
    end
    if (inc_we) e_inc = inc_val;
  endtask

  task automatic check(input string req);
    checks++;
    if (sec_q !== e_sec || nsec_q !== e_nsec) begin
      failures++;
      $display("FAIL %s: sec=%0d nsec=%0d expected sec=%0d nsec=%0d",
               req, sec_q, nsec_q, e_sec, e_nsec);
    end
  endtask

  task automatic cyc(input logic t, input logic m, input logic we, input logic [NW-1:0] iv,
                     input logic ld, input logic [SW-1:0] ls, input logic [NW-1:0] ln,
                     input string req);
    @(negedge clk);
    tick = t; roll_dec = m; inc_we = we; inc_val = iv;
    ld_en = ld; ld_sec = ls; ld_nsec = ln;
    @(posedge clk);
    model_step();
    #1;
    check(req);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(1, 1, 1, 31'd77, 1, 32'd5, 31'd9, "R1");
    rst = 1'b0;
    cyc(1, 1, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, 0, "R2");
    // write increment together with a tick: old (zero) increment applies
    cyc(1, 1, 1, 31'd40, 0, 0, 0, "R8");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3");
    cyc(0, 1, 0, 0, 0, 0, 0, "R6");
    // decimal wrap
    cyc(0, 1, 0, 0, 1, 32'd10, 31'd999_999_980, "R7");
    cyc(1, 1, 0, 0, 0, 0, 0, "R4");
    // exact limit reached without wrap
    cyc(0, 1, 0, 0, 1, 32'd10, 31'd999_999_959, "R7");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3");
    // binary wrap
    cyc(0, 0, 0, 0, 1, 32'd3, 31'h7FFF_FFF0, "R7");
    cyc(1, 0, 0, 0, 0, 0, 0, "R5");
    // mode change applies to the next tick: 999,999,990 + 40 no wrap in binary
    cyc(0, 0, 0, 0, 1, 32'd3, 31'd999_999_990, "R7");
    cyc(1, 0, 0, 0, 0, 0, 0, "R10");
    cyc(0, 1, 0, 0, 1, 32'd3, 31'd999_999_990, "R7");
    cyc(1, 1, 0, 0, 0, 0, 0, "R10");
    // seconds wrap
    cyc(0, 1, 0, 0, 1, 32'hFFFF_FFFF, 31'd999_999_999, "R7");
    cyc(1, 1, 0, 0, 0, 0, 0, "R9");
    // load beats tick
    cyc(1, 1, 0, 0, 1, 32'd1234, 31'd5678, "R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic t, m, we, ld;
      logic [NW-1:0] iv;
      t  = ($urandom % 4) != 0;
      m  = ($urandom % 8) != 0;
      we = ($urandom % 16) == 0;
      ld = ($urandom % 32) == 0;
      iv = NW'($urandom % 400_000_000);
      cyc(t, m, we, iv, ld, $urandom, NW'($urandom % 1_000_000_000),
          ld ? "R7" : (t ? "R3" : "R6"));
    end
    finish_run();
  end

  initial void'($urandom(32'd2024));
endmodule